// File: doc/BRIEF.md
# Leap-Frog Segmented DAC Tap Decoder

This block turns a binary converter code into the switch controls of a segmented voltage-output converter. The analog core is a string of equal resistors whose joints form tap nodes, two buffered tap multiplexers, and a fine interpolating sub-converter that spans the voltage between the two chosen taps. The upper code bits pick the coarse segment and the lower bits give the position inside it.

The two multiplexers take turns being the low end of the active segment. Multiplexer A only reaches even-numbered nodes and multiplexer B only odd-numbered ones, so on a one-segment step up one buffer stays on the node both segments share while the other hops over it. Because the interpolator's inputs swap ends on alternate segments, the fine code is inverted on those segments. Every new code is captured on a clock edge where the load strobe is high, so the outputs hold steady between loads.

With defaults there are 16 segments, 17 nodes (0 at the bottom, 16 at the top), a 12-bit fine field and a 16-bit code.

Top module: `leapfrog_dac_decoder`

## Requirements
- R1: While reset is asserted, and right after it, `tap_a_sel` is 9'h001 (node 0), `tap_b_sel` is 8'h01 (node 1) and `fine_code` is zero.
- R2: The segment index k is `code[15:12]`; the fine field is `code[11:0]`.
- R3: After a load, bit i of `tap_a_sel` selects node 2i and bit (k+1)>>1 is the one set, so A sits on node k for even k and on node k+1 for odd k.
- R4: After a load, bit j of `tap_b_sel` selects node 2j+1 and bit k>>1 is the one set, so B sits on node k+1 for even k and on node k for odd k.
- R5: The two selected nodes are always adjacent and bound segment k: the lower one is node k, the upper one node k+1.
- R6: `fine_code` equals `code[11:0]` for even k and its bitwise complement for odd k.
- R7: Outputs change only at a rising clock edge where `load` is 1; at any other edge they hold, whatever `code` does.
- R8: Exactly one bit of `tap_a_sel` and exactly one bit of `tap_b_sel` is set at all times.
- R9: When k rises by one, one multiplexer keeps its node (the shared node k+1 of the old segment) while the other moves.
- R10: With the interpolator modelled at mid-step, the output in half-steps, 8192·nodeA + (2·fine_code+1)·(nodeB−nodeA), equals 2·code+1, so every code is exactly one step above its predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `code` at this rising edge |
| code | input | 16 | Converter code: segment in the top 4 bits, fine value below |
| tap_a_sel | output | 9 | One-hot select of multiplexer A, bit i = node 2i |
| tap_b_sel | output | 8 | One-hot select of multiplexer B, bit j = node 2j+1 |
| fine_code | output | 12 | Code for the interpolating sub-converter |

## Verification
The bench builds the block with its default four segment bits and twelve fine bits. That size keeps the full code space of 65536 values small enough for an exhaustive sweep, so every segment boundary, every multiplexer hand-over and every inversion of the fine field is crossed, and the modelled transfer curve is checked step by step end to end. Directed vectors pin the exact one-hot patterns at the bottom, middle and top segments.

// File: rtl/leapfrog_pkg.sv
package leapfrog_pkg;

    // Default geometry of the converter
    localparam int unsigned DEF_SEG_BITS  = 4;
    localparam int unsigned DEF_FINE_BITS = 12;

    // Which multiplexer drives the low end of the active segment
    typedef enum logic {
        ROLE_A_LOW  = 1'b0,
        ROLE_A_HIGH = 1'b1
    } role_e;

endpackage

// File: rtl/lf_tap_decode.sv
module lf_tap_decode
    import leapfrog_pkg::*;
#(
    parameter int unsigned SEG_BITS = DEF_SEG_BITS,
    localparam int unsigned NSEG    = 1 << SEG_BITS,
    localparam int unsigned NA      = NSEG / 2 + 1,
    localparam int unsigned NB      = NSEG / 2
) (
    input  logic [SEG_BITS-1:0] seg,
    output logic [NA-1:0]       a_sel,
    output logic [NB-1:0]       b_sel,
    output role_e               role
);
    localparam int unsigned IDX_W = SEG_BITS + 1;

    logic [IDX_W-1:0] seg_plus_one;
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;

    // A: even node (k+1) rounded down to even, i.e. index (k+1)>>1
    // B: odd node, index k>>1
    assign seg_plus_one = {1'b0, seg} + IDX_W'(1);
    assign a_idx        = seg_plus_one >> 1;
    assign b_idx        = {1'b0, seg} >> 1;
    assign role         = seg[0] ? ROLE_A_HIGH : ROLE_A_LOW;

    for (genvar gi = 0; gi < NA; gi++) begin : g_a
        assign a_sel[gi] = (a_idx == IDX_W'(gi));
    end

    for (genvar gj = 0; gj < NB; gj++) begin : g_b
        assign b_sel[gj] = (b_idx == IDX_W'(gj));
    end

endmodule

// File: rtl/lf_fine_fold.sv
module lf_fine_fold
    import leapfrog_pkg::*;
#(
    parameter int unsigned FINE_BITS = DEF_FINE_BITS
) (
    input  role_e                raw_role,
    input  logic [FINE_BITS-1:0] raw_fine,
    output logic [FINE_BITS-1:0] fine
);
    logic flip;

    // Interpolator inputs are swapped when A holds the upper node
    assign flip = (raw_role == ROLE_A_HIGH);

    for (genvar gb = 0; gb < FINE_BITS; gb++) begin : g_bit
        assign fine[gb] = raw_fine[gb] ^ flip;
    end

endmodule

// File: rtl/leapfrog_dac_decoder.sv
module leapfrog_dac_decoder
    import leapfrog_pkg::*;
#(
    parameter int unsigned SEG_BITS  = DEF_SEG_BITS,
    parameter int unsigned FINE_BITS = DEF_FINE_BITS,
    localparam int unsigned CODE_W   = SEG_BITS + FINE_BITS,
    localparam int unsigned NSEG     = 1 << SEG_BITS,
    localparam int unsigned NA       = NSEG / 2 + 1,
    localparam int unsigned NB       = NSEG / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CODE_W-1:0]    code,
    output logic [NA-1:0]        tap_a_sel,
    output logic [NB-1:0]        tap_b_sel,
    output logic [FINE_BITS-1:0] fine_code
);
    typedef struct packed {
        logic [NA-1:0]        a;
        logic [NB-1:0]        b;
        logic [FINE_BITS-1:0] fine;
    } drive_t;

    localparam drive_t DRIVE_RESET = '{a: NA'(1), b: NB'(1), fine: '0};

    logic [SEG_BITS-1:0]  seg_w;
    logic [FINE_BITS-1:0] raw_fine_w;
    logic [NA-1:0]        a_sel_w;
    logic [NB-1:0]        b_sel_w;
    logic [FINE_BITS-1:0] fine_w;
    role_e                role_w;

    drive_t drv_d;
    drive_t drv_q;

    assign seg_w      = code[CODE_W-1:FINE_BITS];
    assign raw_fine_w = code[FINE_BITS-1:0];

    lf_tap_decode #(
        .SEG_BITS (SEG_BITS)
    ) u_tap (
        .seg   (seg_w),
        .a_sel (a_sel_w),
        .b_sel (b_sel_w),
        .role  (role_w)
    );

    lf_fine_fold #(
        .FINE_BITS (FINE_BITS)
    ) u_fold (
        .raw_role (role_w),
        .raw_fine (raw_fine_w),
        .fine     (fine_w)
    );

    always_comb begin
        drv_d = drv_q;
        if (load) begin
            drv_d.a    = a_sel_w;
            drv_d.b    = b_sel_w;
            drv_d.fine = fine_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= DRIVE_RESET;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign tap_a_sel = drv_q.a;
    assign tap_b_sel = drv_q.b;
    assign fine_code = drv_q.fine;

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
    parameter int unsigned SEG_BITS  = 4,
    parameter int unsigned FINE_BITS = 12,
    localparam int unsigned CODE_W   = SEG_BITS + FINE_BITS,
    localparam int unsigned NSEG     = 1 << SEG_BITS,
    localparam int unsigned NA       = NSEG / 2 + 1,
    localparam int unsigned NB       = NSEG / 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load,
    input logic [CODE_W-1:0]    code,
    input logic [NA-1:0]        tap_a_sel,
    input logic [NB-1:0]        tap_b_sel,
    input logic [FINE_BITS-1:0] fine_code
);
    int a_node;
    int b_node;

    always_comb begin
        a_node = -100;
        b_node = -100;
        for (int i = 0; i < NA; i++) if (tap_a_sel[i]) a_node = 2 * i;
        for (int j = 0; j < NB; j++) if (tap_b_sel[j]) b_node = 2 * j + 1;
    end

    AST_A_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_a_sel) == 1);                                   // R8
    AST_B_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_b_sel) == 1);                                   // R8
    AST_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_node - b_node == 1) || (b_node - a_node == 1));             // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tap_a_sel) && $stable(tap_b_sel) && $stable(fine_code)); // R7
    AST_FINE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> fine_code == ($past(code[FINE_BITS]) ? ~$past(code[FINE_BITS-1:0])
                                                      :  $past(code[FINE_BITS-1:0]))); // R6

endmodule

bind leapfrog_dac_decoder lf_checker #(
    .SEG_BITS  (SEG_BITS),
    .FINE_BITS (FINE_BITS)
) u_lf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .code      (code),
    .tap_a_sel (tap_a_sel),
    .tap_b_sel (tap_b_sel),
    .fine_code (fine_code)
);

// File: tb/tb_leapfrog_dac_decoder.sv
module tb_leapfrog_dac_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // {code, expected A select, expected B select, expected fine code}
    localparam logic [44:0] VEC [NVEC] = '{
        {16'h0000, 9'h001, 8'h01, 12'h000},
        {16'h0ABC, 9'h001, 8'h01, 12'hABC},
        {16'h1000, 9'h002, 8'h01, 12'hFFF},
        {16'h1ABC, 9'h002, 8'h01, 12'h543},
        {16'h2123, 9'h002, 8'h02, 12'h123},
        {16'h3FFF, 9'h004, 8'h02, 12'h000},
        {16'h7800, 9'h010, 8'h08, 12'h7FF},
        {16'h8000, 9'h010, 8'h10, 12'h000},
        {16'hE00F, 9'h080, 8'h80, 12'h00F},
        {16'hF000, 9'h100, 8'h80, 12'hFFF},
        {16'hFFFF, 9'h100, 8'h80, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] code = '0;
    logic [8:0]  tap_a_sel;
    logic [7:0]  tap_b_sel;
    logic [11:0] fine_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    leapfrog_dac_decoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .code      (code),
        .tap_a_sel (tap_a_sel),
        .tap_b_sel (tap_b_sel),
        .fine_code (fine_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int a_node_of(input logic [8:0] v);
        int n = -100;
        if ($countones(v) != 1) return -100;
        for (int i = 0; i < 9; i++) if (v[i]) n = 2 * i;
        return n;
    endfunction

    function automatic int b_node_of(input logic [7:0] v);
        int n = -100;
        if ($countones(v) != 1) return -100;
        for (int j = 0; j < 8; j++) if (v[j]) n = 2 * j + 1;
        return n;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk(tap_a_sel == 9'h001, "R1", {tag, " A select"}, tap_a_sel, 9'h001);
        chk(tap_b_sel == 8'h01,  "R1", {tag, " B select"}, tap_b_sel, 8'h01);
        chk(fine_code == 12'h0,  "R1", {tag, " fine"},     fine_code, 0);
    endtask

    // Load one code; outputs are valid at the following negedge
    task automatic apply(input logic [15:0] c);
        @(negedge clk);
        code = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pa, pb, pk, fa, fb, fo, v2, na, nb, k;
        logic [8:0]  ha;
        logic [7:0]  hb;
        logic [11:0] hf;

        // R1: reset state, while held and just after release
        repeat (3) @(negedge clk);
        check_reset_state("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after release");

        // R2 R3 R4 R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][44:29]);
            chk(tap_a_sel == VEC[i][28:20], "R3", $sformatf("A for %h", VEC[i][44:29]),
                tap_a_sel, VEC[i][28:20]);
            chk(tap_b_sel == VEC[i][19:12], "R4", $sformatf("B for %h", VEC[i][44:29]),
                tap_b_sel, VEC[i][19:12]);
            chk(fine_code == VEC[i][11:0], "R6", $sformatf("fine for %h (R2 split)", VEC[i][44:29]),
                fine_code, VEC[i][11:0]);
        end

        // R7: code moves without load, outputs must hold
        apply(16'h5321);
        ha = tap_a_sel; hb = tap_b_sel; hf = fine_code;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            code = 16'hA000 + 16'(i * 16'h1111);
        end
        @(negedge clk);
        chk(tap_a_sel == ha, "R7", "A held without load", tap_a_sel, ha);
        chk(tap_b_sel == hb, "R7", "B held without load", tap_b_sel, hb);
        chk(fine_code == hf, "R7", "fine held without load", fine_code, hf);

        // Exhaustive sweep with load held high: R5 R8 R9 R10
        fa = 0; fb = 0; fo = 0;
        pa = -1; pb = -1; pk = -1;
        @(negedge clk);
        code = 16'h0000;
        load = 1'b1;
        for (int c = 0; c < 65536; c++) begin
            @(negedge clk);
            k  = c >> 12;
            na = a_node_of(tap_a_sel);
            nb = b_node_of(tap_b_sel);
            checks++;
            if (na < 0 || nb < 0) begin
                errors++;
                $display("FAIL R8 code %h: actual A %h B %h expected one-hot", c, tap_a_sel, tap_b_sel);
            end else begin
                v2 = 8192 * na + (2 * int'(fine_code) + 1) * (nb - na);
                if (((na < nb) ? na : nb) != k || ((na > nb) ? na : nb) != k + 1) begin
                    errors++;
                    $display("FAIL R5 code %h: actual nodes %0d/%0d expected %0d/%0d", c, na, nb, k, k + 1);
                end else if (v2 != 2 * c + 1) begin
                    errors++;
                    $display("FAIL R10 code %h: actual level %0d expected %0d", c, v2, 2 * c + 1);
                end else if (pk >= 0 && k == pk + 1 && !((na == pa) ^ (nb == pb))) begin
                    errors++;
                    $display("FAIL R9 code %h: actual A %0d->%0d B %0d->%0d expected one kept", c, pa, na, pb, nb);
                end
            end
            pa = na; pb = nb; pk = k;
            if (c < 65535) code = 16'(c + 1);
        end
        load = 1'b0;

        // R1: reset mid-run returns to segment 0
        apply(16'hC777);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after second release");

        finish_run();
    end

endmodule